// File: doc/BRIEF.md
# Packed-Decimal Adder/Subtractor

This block adds or subtracts two packed decimal words. Each word holds NUM_DIGITS decimal digits, one digit per 4-bit group. Digit 0 is the least significant and sits in bits [3:0]. The digits are combined one group at a time, from the least significant group upward. A decimal carry passes from each group into the next.

Each digit group first forms a plain binary sum. If that sum is larger than 9, the group adds 6 to correct it, keeps the low four bits, and raises a decimal carry. For subtraction, each digit of the second operand is replaced by its nine's complement. The extra one that completes the ten's complement enters as the carry into digit 0. A negative difference therefore comes out in ten's complement form.

The carry out of the top digit is reported on its own pin and is not part of the result word. The result can be taken straight from the logic, or from a register stage selected by a parameter.

Top module: `bcd_addsub`

## Requirements
- R1: Each output digit is the decimal sum of its two input digits plus the incoming decimal carry. When the binary digit sum exceeds 9, the digit is corrected and a carry goes to the next digit. For example, 0005 + 0007 gives 0012, and 0909 + 0091 gives 1000.
- R2: When sub_i = 0, sum_o is (A + B) mod 10^NUM_DIGITS. For example, 0255 + 0063 gives 0318 with carry_o = 0.
- R3: When sub_i = 0, carry_o is 1 exactly when A + B is at least 10^NUM_DIGITS. For example, 9999 + 0001 gives 0000 with carry 1, and 9999 + 9999 gives 9998 with carry 1.
- R4: When sub_i = 1, sum_o is A + (nine's complement of B) + 1, taken mod 10^NUM_DIGITS, and carry_o = 1 when A ≥ B. For example, 0255 − 0063 gives 0192 with carry 1, and 1000 − 0001 gives 0999 with carry 1.
- R5: When sub_i = 1 and A < B, sum_o is the ten's complement 10^NUM_DIGITS − (B − A) and carry_o = 0. For example, 0021 − 0034 gives 9987, and 0000 − 0001 gives 9999.
- R6: When sub_i = 1 and B = A, or when B = 0000, the injected plus-one carries through every digit. The results are A − A = 0000 with carry 1, and A − 0000 = A with carry 1.
- R7: For valid decimal inputs, every output digit is in the range 0 to 9.
- R8: With REG_OUT = 1, sum_o and carry_o change only on a rising clk edge and show the result for the inputs sampled at that edge. A cycle with rst = 1 (synchronous, active high) clears them to 0000 with carry 0. With REG_OUT = 0, the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opa_i | input | 4*NUM_DIGITS | First operand, packed decimal, digit 0 in bits [3:0] |
| opb_i | input | 4*NUM_DIGITS | Second operand (addend or subtrahend), packed decimal |
| sub_i | input | 1 | 1 = subtract opb_i from opa_i, 0 = add |
| sum_o | output | 4*NUM_DIGITS | Decimal result; a negative difference is in ten's complement form |
| carry_o | output | 1 | Decimal carry out of the top digit; for subtraction, 1 means the result is not negative |

## Verification
The bench builds two copies of the block with NUM_DIGITS = 4, so that the four-digit examples can be checked directly. One copy uses REG_OUT = 1 and the other uses REG_OUT = 0. Running both on the same inputs shows that the registered path adds exactly one edge of latency and is cleared by reset. It also shows that the combinational path gives the same value with no clock. With four digits, boundary values such as 9999 + 0001 and 0000 − 0001 can be reached directly, so a carry that must cross every digit is checked on both the add and the subtract path.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DEC_MAX   = 9;
    localparam int DEC_ADJ   = 6;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    typedef struct packed {
        logic       carry;
        bcd_digit_t digit;
    } digit_res_t;

    function automatic bcd_digit_t nines_of(input bcd_digit_t d);
        return bcd_digit_t'(DEC_MAX) - d;
    endfunction

    function automatic logic digit_ok(input bcd_digit_t d);
        return d <= bcd_digit_t'(DEC_MAX);
    endfunction

    function automatic digit_res_t digit_add(input bcd_digit_t a,
                                             input bcd_digit_t b,
                                             input logic       cin);
        logic [DIGIT_W:0] raw;
        logic [DIGIT_W:0] adj;
        digit_res_t       r;
        raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
        adj = raw + (DIGIT_W+1)'(DEC_ADJ);
        if (raw > (DIGIT_W+1)'(DEC_MAX)) begin
            r.carry = 1'b1;
            r.digit = adj[DIGIT_W-1:0];
        end else begin
            r.carry = 1'b0;
            r.digit = raw[DIGIT_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_arith_pkg::*;
(
    input  bcd_digit_t a_i,
    input  bcd_digit_t b_i,
    input  logic       cin_i,
    output bcd_digit_t sum_o,
    output logic       cout_o
);

    digit_res_t res;

    always_comb begin
        res    = digit_add(a_i, b_i, cin_i);
        sum_o  = res.digit;
        cout_o = res.carry;
    end

    always_comb begin
        if (digit_ok(a_i) && digit_ok(b_i)) begin
            // R7
            digit_range_chk: assert (digit_ok(sum_o));
            // R1
            digit_weight_chk: assert ((6'(a_i) + 6'(b_i) + 6'(cin_i))
                                      == (6'(sum_o) + (cout_o ? 6'd10 : 6'd0)));
        end
    end

endmodule

// File: rtl/bcd_operand_cond.sv
module bcd_operand_cond
    import bcd_arith_pkg::*;
#(
    parameter int NUM_DIGITS = 4
)(
    input  logic [NUM_DIGITS*DIGIT_W-1:0] opb_i,
    input  logic                          sub_i,
    output logic [NUM_DIGITS*DIGIT_W-1:0] opb_o
);

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        assign opb_o[g*DIGIT_W +: DIGIT_W] =
            sub_i ? nines_of(opb_i[g*DIGIT_W +: DIGIT_W])
                  : opb_i[g*DIGIT_W +: DIGIT_W];
    end

endmodule

// File: rtl/bcd_ripple_chain.sv
module bcd_ripple_chain
    import bcd_arith_pkg::*;
#(
    parameter int NUM_DIGITS = 4
)(
    input  logic [NUM_DIGITS*DIGIT_W-1:0] opa_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] opb_i,
    input  logic                          cin_i,
    output logic [NUM_DIGITS*DIGIT_W-1:0] sum_o,
    output logic                          cout_o
);

    logic [NUM_DIGITS:0] link;

    assign link[0] = cin_i;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cell
        bcd_digit_cell u_cell (
            .a_i    (opa_i[g*DIGIT_W +: DIGIT_W]),
            .b_i    (opb_i[g*DIGIT_W +: DIGIT_W]),
            .cin_i  (link[g]),
            .sum_o  (sum_o[g*DIGIT_W +: DIGIT_W]),
            .cout_o (link[g+1])
        );
    end

    assign cout_o = link[NUM_DIGITS];

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
    import bcd_arith_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter bit REG_OUT    = 1'b1
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] opa_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] opb_i,
    input  logic                          sub_i,
    output logic [NUM_DIGITS*DIGIT_W-1:0] sum_o,
    output logic                          carry_o
);

    localparam int W = NUM_DIGITS * DIGIT_W;

    logic [W-1:0] b_eff;
    logic [W-1:0] comb_sum;
    logic         comb_carry;

    function automatic logic word_ok(input logic [W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_DIGITS; i++)
            ok = ok & digit_ok(w[i*DIGIT_W +: DIGIT_W]);
        return ok;
    endfunction

    bcd_operand_cond #(.NUM_DIGITS(NUM_DIGITS)) u_cond (
        .opb_i (opb_i),
        .sub_i (sub_i),
        .opb_o (b_eff)
    );

    bcd_ripple_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
        .opa_i  (opa_i),
        .opb_i  (b_eff),
        .cin_i  (sub_i),
        .sum_o  (comb_sum),
        .cout_o (comb_carry)
    );

    if (REG_OUT) begin : g_reg
        logic [W-1:0] sum_q;
        logic         carry_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sum_q   <= '0;
                carry_q <= 1'b0;
            end else begin
                sum_q   <= comb_sum;
                carry_q <= comb_carry;
            end
        end

        assign sum_o   = sum_q;
        assign carry_o = carry_q;

        // R8
        reg_latency_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (sum_o == $past(comb_sum) && carry_o == $past(comb_carry)));
    end else begin : g_comb
        assign sum_o   = comb_sum;
        assign carry_o = comb_carry;
    end

    // R6
    self_diff_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_i && opa_i == opb_i && word_ok(opa_i)) |-> (comb_sum == '0 && comb_carry));

    // R6
    zero_subtrahend_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_i && opb_i == '0 && word_ok(opa_i)) |-> (comb_sum == opa_i && comb_carry));

endmodule

// File: tb/tb_bcd_addsub.sv
`timescale 1ns/1ps
module tb_bcd_addsub;

    localparam int ND = 4;
    localparam int W  = ND * 4;
    localparam int NV = 13;
    localparam int MODV = 10000;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a, b;
    logic         sub;
    logic [W-1:0] s_r, s_c;
    logic         c_r, c_c;

    always #4 clk = ~clk;

    bcd_addsub #(.NUM_DIGITS(ND), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .opa_i(a), .opb_i(b), .sub_i(sub),
        .sum_o(s_r), .carry_o(c_r));

    bcd_addsub #(.NUM_DIGITS(ND), .REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst(rst), .opa_i(a), .opb_i(b), .sub_i(sub),
        .sum_o(s_c), .carry_o(c_c));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // {a, b, sub, expected sum, expected carry}
    localparam logic [49:0] VECS [NV] = '{
        {16'h0005, 16'h0007, 1'b0, 16'h0012, 1'b0},
        {16'h0909, 16'h0091, 1'b0, 16'h1000, 1'b0},
        {16'h0255, 16'h0063, 1'b0, 16'h0318, 1'b0},
        {16'h9999, 16'h0001, 1'b0, 16'h0000, 1'b1},
        {16'h5000, 16'h5000, 1'b0, 16'h0000, 1'b1},
        {16'h9999, 16'h9999, 1'b0, 16'h9998, 1'b1},
        {16'h0255, 16'h0063, 1'b1, 16'h0192, 1'b1},
        {16'h1000, 16'h0001, 1'b1, 16'h0999, 1'b1},
        {16'h0021, 16'h0034, 1'b1, 16'h9987, 1'b0},
        {16'h0000, 16'h0001, 1'b1, 16'h9999, 1'b0},
        {16'h1234, 16'h0000, 1'b1, 16'h1234, 1'b1},
        {16'h4321, 16'h4321, 1'b1, 16'h0000, 1'b1},
        {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}
    };
    string tags [NV] = '{"R1", "R1", "R2", "R3", "R3", "R3", "R4",
                         "R4", "R5", "R5", "R6", "R6", "R2"};

    logic [W-1:0] prev_s;
    logic         prev_c;

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int t;
        t = v;
        for (int i = 0; i < ND; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic bit digits_ok(input logic [W-1:0] w);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < ND; i++)
            if (w[i*4 +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    task automatic chk(input string tag, input logic [W:0] got, input logic [W:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got carry=%b sum=%h, expected carry=%b sum=%h",
                     tag, got[W], got[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vs,
                         input logic [W-1:0] es, input logic ec, input string tag);
        @(negedge clk);
        a = va; b = vb; sub = vs;
        #1;
        chk(tag, {c_c, s_c}, {ec, es});
        // R8: registered output holds its previous value until the edge
        chk("R8 hold", {c_r, s_r}, {prev_c, prev_s});
        @(negedge clk);
        chk(tag, {c_r, s_r}, {ec, es});
        // R7
        if (!digits_ok(s_c)) chk("R7", {c_c, s_c}, {ec, es});
        prev_s = es; prev_c = ec;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; a = 16'h9999; b = 16'h9999; sub = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R8: reset clears the registered outputs even with live inputs
        chk("R8 reset", {c_r, s_r}, {1'b0, 16'h0000});
        // R8: the combinational copy follows its inputs during reset
        chk("R8 comb", {c_c, s_c}, {1'b1, 16'h9998});
        rst = 1'b0;
        prev_s = '0; prev_c = 1'b0;
        a = '0; b = '0;
        @(negedge clk);
        prev_s = '0; prev_c = 1'b0;

        for (int i = 0; i < NV; i++)
            apply(VECS[i][49:34], VECS[i][33:18], VECS[i][17],
                  VECS[i][16:1], VECS[i][0], tags[i]);

        for (int i = 0; i < 200; i++) begin
            int va, vb, ev;
            bit vs, ec;
            string tg;
            va = (i * 379 + 17) % MODV;
            vb = (i * 7919 + 3) % MODV;
            vs = i[0];
            if (vs) begin
                ev = va - vb;
                ec = (ev >= 0);
                if (ev < 0) ev = ev + MODV;
                tg = ec ? "R4" : "R5";
            end else begin
                ev = va + vb;
                ec = (ev >= MODV);
                ev = ev % MODV;
                tg = ec ? "R3" : "R2";
            end
            apply(to_bcd(va), to_bcd(vb), vs, to_bcd(ev), ec, tg);
        end

        // R8: reset in mid-stream clears the registered result
        @(negedge clk);
        rst = 1'b1; a = 16'h0021; b = 16'h0034; sub = 1'b1;
        @(negedge clk);
        chk("R8 reset", {c_r, s_r}, {1'b0, 16'h0000});
        rst = 1'b0;
        @(negedge clk);
        chk("R5", {c_r, s_r}, {1'b0, 16'h9987});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule